// File: doc/BRIEF.md
# Trace ID Sink Filter Unit

This block sits between a trace stream and two trace buffer sinks. Every incoming beat carries a 7-bit trace ID, a sink selector and a data word. The unit looks up the selected sink's enable bit for that ID. When the bit is set, the beat is handed to that sink through a valid/ready handshake. When the bit is clear, the beat is consumed at once and vanishes. A filtered ID therefore never holds up the source.

Each sink owns a 128-bit enable map, one bit per trace ID, spread over four 32-bit words. Software programs the maps through an APB-style slave port. It reads a word, flips the bit for one ID and writes the word back. Map writes take effect only while a lock-access register holds the unlock key.

Two small state machines carry the behaviour. The lock machine has states LOCKED and OPEN. A write of the key to the lock-access register takes it from LOCKED to OPEN. A write of any other value takes it, or keeps it, in LOCKED. The stream machine has states EMPTY and FULL:
- EMPTY to FULL: an accepted beat whose bit is set.
- EMPTY to EMPTY: a dropped beat.
- FULL to EMPTY: the held beat is taken by its sink and no new passing beat arrives in that cycle.
- FULL to FULL: the held beat is still stalled, or it is taken and a new passing beat is loaded in the same cycle.

Top module: `trace_id_filter`

## Requirements
- R1: After reset all map words read 0. The lock status register at byte offset 0xFB4 reads 1 in bit 0, which means locked. No sink valid is asserted, and every beat is dropped.
- R2: Writing 0xC5ACCE55 to the lock-access register at offset 0xFB0 unlocks the unit, and the status bit reads 0. Writing any other value there locks it, and the status bit reads 1.
- R3: Writes to map words while the unit is locked are ignored, and the readback is unchanged.
- R4: The enable bit for trace ID n of sink s is bit n mod 32 of the word at byte offset base_s + (n/32)*4. base_0 is 0xF8 and base_1 is 0x108. Every map word reads back the full 32-bit value written, so a read-modify-write keeps the other bits.
- R5: An accepted beat whose bit is set in the map of the sink chosen by in_dest (0 or 1) appears on that sink in the cycle after acceptance. Only snk_valid[in_dest] is high, and the ID and data are unchanged.
- R6: A beat whose bit is clear for its selected sink is accepted with in_ready high and never appears on any sink.
- R7: While a forwarded beat waits with its sink's ready low, its valid, ID and data stay stable, and a further passing beat is not accepted.
- R8: A dropped beat is accepted even while a forwarded beat is stalled, and the stalled beat is left intact.
- R9: Reads of unmapped offsets return 0, and writes to unmapped offsets change no map word.
- R10: A map write is applied to the first beat presented after the write's access cycle.
- R11: With the sink ready, passing beats presented on consecutive cycles are all accepted and delivered one per cycle in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write strobe |
| paddr | input | 12 | Register byte address |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data |
| pready | output | 1 | Register port ready, always 1 |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_dest | input | 1 | Sink selector of the beat |
| in_id | input | 7 | Trace ID of the beat |
| in_data | input | 32 | Beat payload |
| snk_valid | output | 2 | Per-sink valid of the held beat |
| snk_ready | input | 2 | Per-sink ready |
| snk_id | output | 7 | Trace ID of the held beat |
| snk_data | output | 32 | Payload of the held beat |

## Verification
Some rules are checked on every cycle against the live signals:
- A beat that misses the map is never back-pressured.
- A hit produces exactly the matching sink valid one cycle later.
- A stalled beat holds still.
- Locked map writes and unmapped reads leave no trace.
- A non-key write to the lock register leaves the unit locked.

The directed scenarios cover what needs a planned sequence and known values:
- The bit and word position of a given ID in each sink's map.
- Read-modify-write keeping the neighbouring bits.
- A map update landing on the very next beat.
- A drop slipping past a stalled beat.
- Full-rate bursts arriving in order.

// File: rtl/tidf_pkg.sv
package tidf_pkg;
    localparam int unsigned TIDF_MAX_SINKS = 2;
    localparam int unsigned TIDF_WORD_W    = 32;
    localparam logic [31:0] TIDF_KEY       = 32'hC5AC_CE55;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

    typedef enum logic {
        RT_EMPTY = 1'b0,
        RT_FULL  = 1'b1
    } route_state_e;
endpackage

// File: rtl/tidf_lock.sv
module tidf_lock
    import tidf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    output logic        unlocked
);
    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (key_data == TIDF_KEY)
                1'b1: state_d = LK_OPEN;
                1'b0: state_d = LK_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LK_OPEN:   unlocked = 1'b1;
            LK_LOCKED: unlocked = 1'b0;
        endcase
    end
endmodule

// File: rtl/tidf_regbank.sv
module tidf_regbank
    import tidf_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned ID_W       = 7,
    parameter int unsigned NSINK      = 2,
    parameter logic [11:0] SINK0_BASE = 12'h0F8,
    parameter logic [11:0] SINK1_BASE = 12'h108,
    parameter logic [11:0] STAT_ADDR  = 12'hFB4,
    localparam int unsigned IDS       = 1 << ID_W,
    localparam int unsigned WORDS     = IDS / TIDF_WORD_W,
    localparam int unsigned DEST_W    = (NSINK > 1) ? $clog2(NSINK) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    input  logic                    unlocked,
    output logic [31:0]             rdata,
    input  logic [DEST_W-1:0]       look_dest,
    input  logic [ID_W-1:0]         look_id,
    output logic                    look_hit,
    output logic [NSINK*IDS-1:0]    map_flat
);
    logic [NSINK-1:0][WORDS-1:0][TIDF_WORD_W-1:0] words_q;

    function automatic logic [ADDR_W-1:0] word_addr(int s, int w);
        logic [ADDR_W-1:0] base;
        base = (s == 0) ? ADDR_W'(SINK0_BASE) : ADDR_W'(SINK1_BASE);
        return base + ADDR_W'(4 * w);
    endfunction

    for (genvar s = 0; s < NSINK; s++) begin : g_sink
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    words_q[s][w] <= '0;
                else if (wr_en && unlocked && addr == word_addr(s, w))
                    words_q[s][w] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < NSINK; s++) begin
            for (int w = 0; w < WORDS; w++) begin
                if (addr == word_addr(s, w)) rdata = words_q[s][w];
            end
        end
        if (addr == ADDR_W'(STAT_ADDR)) rdata = {31'b0, ~unlocked};
    end

    assign map_flat = words_q;
    assign look_hit = map_flat[{look_dest, look_id}];
endmodule

// File: rtl/tidf_route.sv
module tidf_route
    import tidf_pkg::*;
#(
    parameter int unsigned ID_W   = 7,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NSINK  = 2,
    localparam int unsigned DEST_W = (NSINK > 1) ? $clog2(NSINK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DEST_W-1:0] in_dest,
    input  logic [ID_W-1:0]   in_id,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_hit,
    output logic [NSINK-1:0]  snk_valid,
    input  logic [NSINK-1:0]  snk_ready,
    output logic [ID_W-1:0]   snk_id,
    output logic [DATA_W-1:0] snk_data
);
    route_state_e      state_q, state_d;
    logic [DEST_W-1:0] dest_q;
    logic [ID_W-1:0]   id_q;
    logic [DATA_W-1:0] data_q;
    logic              fire, take;

    assign fire = (state_q == RT_FULL) && snk_ready[dest_q];
    assign take = in_valid && in_ready && in_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_EMPTY: if (take) state_d = RT_FULL;
            RT_FULL:  if (fire && !take) state_d = RT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RT_EMPTY;
            dest_q  <= '0;
            id_q    <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                dest_q <= in_dest;
                id_q   <= in_id;
                data_q <= in_data;
            end
        end
    end

    always_comb begin
        snk_valid = '0;
        unique case (state_q)
            RT_EMPTY: in_ready = 1'b1;
            RT_FULL: begin
                in_ready          = !in_hit || fire;
                snk_valid[dest_q] = 1'b1;
            end
        endcase
        snk_id   = id_q;
        snk_data = data_q;
    end
endmodule

// File: rtl/trace_id_filter.sv
module trace_id_filter
    import tidf_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned ID_W       = 7,
    parameter int unsigned DATA_W     = 32,
    parameter logic [11:0] SINK0_BASE = 12'h0F8,
    parameter logic [11:0] SINK1_BASE = 12'h108,
    parameter logic [11:0] KEY_ADDR   = 12'hFB0,
    parameter logic [11:0] STAT_ADDR  = 12'hFB4,
    localparam int unsigned NSINK     = TIDF_MAX_SINKS,
    localparam int unsigned IDS       = 1 << ID_W,
    localparam int unsigned DEST_W    = $clog2(NSINK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DEST_W-1:0] in_dest,
    input  logic [ID_W-1:0]   in_id,
    input  logic [DATA_W-1:0] in_data,
    output logic [NSINK-1:0]  snk_valid,
    input  logic [NSINK-1:0]  snk_ready,
    output logic [ID_W-1:0]   snk_id,
    output logic [DATA_W-1:0] snk_data
);
    logic                 wr_en;
    logic                 unlocked;
    logic                 in_hit;
    logic [NSINK*IDS-1:0] map_flat;

    assign wr_en  = psel && penable && pwrite;
    assign pready = 1'b1;

    tidf_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_en && paddr == ADDR_W'(KEY_ADDR)),
        .key_data (pwdata),
        .unlocked (unlocked)
    );

    tidf_regbank #(
        .ADDR_W     (ADDR_W),
        .ID_W       (ID_W),
        .NSINK      (NSINK),
        .SINK0_BASE (SINK0_BASE),
        .SINK1_BASE (SINK1_BASE),
        .STAT_ADDR  (STAT_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (paddr),
        .wdata     (pwdata),
        .unlocked  (unlocked),
        .rdata     (prdata),
        .look_dest (in_dest),
        .look_id   (in_id),
        .look_hit  (in_hit),
        .map_flat  (map_flat)
    );

    tidf_route #(
        .ID_W   (ID_W),
        .DATA_W (DATA_W),
        .NSINK  (NSINK)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_dest   (in_dest),
        .in_id     (in_id),
        .in_data   (in_data),
        .in_hit    (in_hit),
        .snk_valid (snk_valid),
        .snk_ready (snk_ready),
        .snk_id    (snk_id),
        .snk_data  (snk_data)
    );
endmodule

// File: rtl/tidf_checker.sv
module tidf_checker #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned ID_W       = 7,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NSINK      = 2,
    parameter int unsigned DEST_W     = 1,
    parameter int unsigned MAP_W      = 256,
    parameter logic [11:0] SINK0_BASE = 12'h0F8,
    parameter logic [11:0] SINK1_BASE = 12'h108,
    parameter logic [11:0] KEY_ADDR   = 12'hFB0,
    parameter logic [11:0] STAT_ADDR  = 12'hFB4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DEST_W-1:0] in_dest,
    input logic              in_hit,
    input logic [NSINK-1:0]  snk_valid,
    input logic [NSINK-1:0]  snk_ready,
    input logic [ID_W-1:0]   snk_id,
    input logic [DATA_W-1:0] snk_data,
    input logic [MAP_W-1:0]  map_flat,
    input logic              unlocked
);
    logic wr;
    logic mapped;
    assign wr = psel && penable && pwrite;

    always_comb begin
        mapped = (paddr == ADDR_W'(KEY_ADDR)) || (paddr == ADDR_W'(STAT_ADDR));
        for (int w = 0; w < 4; w++) begin
            if (paddr == ADDR_W'(SINK0_BASE) + ADDR_W'(4 * w)) mapped = 1'b1;
            if (paddr == ADDR_W'(SINK1_BASE) + ADDR_W'(4 * w)) mapped = 1'b1;
        end
    end

    assert_bad_key_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == ADDR_W'(KEY_ADDR) && pwdata != 32'hC5AC_CE55) |=> !unlocked);

    assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !unlocked) |=> $stable(map_flat));

    assert_hit_delivered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_hit) |=> (snk_valid == (NSINK'(1) << $past(in_dest))));

    assert_single_sink_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(snk_valid));

    assert_miss_never_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_hit) |-> in_ready);

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(snk_valid & ~snk_ready)) |=>
            ($stable(snk_valid) && $stable(snk_id) && $stable(snk_data)));

    assert_unmapped_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && !mapped) |-> (prdata == 32'h0));
endmodule

bind trace_id_filter tidf_checker #(
    .ADDR_W     (ADDR_W),
    .ID_W       (ID_W),
    .DATA_W     (DATA_W),
    .NSINK      (NSINK),
    .DEST_W     (DEST_W),
    .MAP_W      (NSINK * IDS),
    .SINK0_BASE (SINK0_BASE),
    .SINK1_BASE (SINK1_BASE),
    .KEY_ADDR   (KEY_ADDR),
    .STAT_ADDR  (STAT_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_dest   (in_dest),
    .in_hit    (in_hit),
    .snk_valid (snk_valid),
    .snk_ready (snk_ready),
    .snk_id    (snk_id),
    .snk_data  (snk_data),
    .map_flat  (map_flat),
    .unlocked  (unlocked)
);

// File: tb/trace_id_filter_test.sv
`timescale 1ns/1ps
module trace_id_filter_test;
    localparam logic [31:0] KEY = 32'hC5AC_CE55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [0:0]  in_dest = '0;
    logic [6:0]  in_id = '0;
    logic [31:0] in_data = '0;
    logic [1:0]  snk_valid;
    logic [1:0]  snk_ready = 2'b11;
    logic [6:0]  snk_id;
    logic [31:0] snk_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    trace_id_filter uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_id(in_id),
        .in_data(in_data), .snk_valid(snk_valid), .snk_ready(snk_ready),
        .snk_id(snk_id), .snk_data(snk_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // Present one beat with the sinks ready; check acceptance and delivery.
    task automatic send_beat(input logic d, input logic [6:0] id, input logic [31:0] data,
                             input bit pass, input string req);
        in_valid = 1'b1; in_dest = d; in_id = id; in_data = data;
        #1 check(in_ready == 1'b1, req, {31'b0, in_ready}, 32'h1);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        if (pass) begin
            check(snk_valid == (2'b01 << d), req, {30'b0, snk_valid}, {30'b0, 2'b01 << d});
            check(snk_data == data && snk_id == id, req, snk_data, data);
        end else begin
            check(snk_valid == 2'b00, req, {30'b0, snk_valid}, 32'h0);
        end
    endtask

    task automatic t_reset;
        apb_read(12'hFB4, rd);
        check(rd == 32'h1, "R1 locked after reset", rd, 32'h1);
        for (int w = 0; w < 4; w++) begin
            apb_read(12'h0F8 + 12'(4 * w), rd);
            check(rd == 32'h0, "R1 sink0 map zero", rd, 32'h0);
            apb_read(12'h108 + 12'(4 * w), rd);
            check(rd == 32'h0, "R1 sink1 map zero", rd, 32'h0);
        end
        @(negedge clk);
        send_beat(1'b0, 7'd5, 32'h1111_0005, 1'b0, "R1 beat dropped after reset");
    endtask

    task automatic t_lock;
        apb_write(12'hFB0, 32'h1234_5678);
        apb_read(12'hFB4, rd);
        check(rd == 32'h1, "R2 wrong key stays locked", rd, 32'h1);
        apb_write(12'hFB0, KEY);
        apb_read(12'hFB4, rd);
        check(rd == 32'h0, "R2 key unlocks", rd, 32'h0);
        apb_write(12'hFB0, 32'h0);
        apb_read(12'hFB4, rd);
        check(rd == 32'h1, "R2 other value relocks", rd, 32'h1);
    endtask

    task automatic t_locked_write;
        apb_write(12'h0F8, 32'hFFFF_FFFF);
        apb_read(12'h0F8, rd);
        check(rd == 32'h0, "R3 locked write ignored", rd, 32'h0);
        @(negedge clk);
        send_beat(1'b0, 7'd3, 32'h3, 1'b0, "R3 locked write left ID dropped");
    endtask

    task automatic t_map;
        apb_write(12'hFB0, KEY);
        // ID 37 of sink 0: word 1 (0xFC), bit 5
        apb_write(12'h0FC, 32'h0000_0020);
        apb_read(12'h0FC, rd);
        check(rd == 32'h0000_0020, "R4 sink0 word1 readback", rd, 32'h0000_0020);
        // Sink 1 word 3 (0x114): bit 0 enables ID 96, plus other bits
        apb_write(12'h114, 32'hA5A5_0001);
        apb_read(12'h114, rd);
        check(rd == 32'hA5A5_0001, "R4 sink1 word3 readback", rd, 32'hA5A5_0001);
        // Read-modify-write: add ID 97 (bit 1)
        apb_read(12'h114, rd);
        apb_write(12'h114, rd | 32'h2);
        apb_read(12'h114, rd);
        check(rd == 32'hA5A5_0003, "R4 read-modify-write keeps bits", rd, 32'hA5A5_0003);
        @(negedge clk);
        send_beat(1'b0, 7'd37, 32'hCAFE_0025, 1'b1, "R5 ID37 to sink0");
        send_beat(1'b1, 7'd96, 32'hBEEF_0060, 1'b1, "R5 ID96 to sink1");
        send_beat(1'b1, 7'd97, 32'hBEEF_0061, 1'b1, "R4 ID97 after RMW");
        send_beat(1'b1, 7'd37, 32'h0BAD_0025, 1'b0, "R6 ID37 clear in sink1");
        send_beat(1'b0, 7'd96, 32'h0BAD_0060, 1'b0, "R6 ID96 clear in sink0");
        send_beat(1'b0, 7'd36, 32'h0BAD_0024, 1'b0, "R4 neighbour ID36 dropped");
    endtask

    task automatic t_update;
        // ID 64 of sink 0: word 2 (0x100), bit 0; beat right after the write
        apb_write(12'h100, 32'h0000_0001);
        send_beat(1'b0, 7'd64, 32'h0000_0040, 1'b1, "R10 update applied to next beat");
        apb_write(12'h100, 32'h0000_0000);
        send_beat(1'b0, 7'd64, 32'h0000_0041, 1'b0, "R10 clear applied to next beat");
    endtask

    task automatic t_unmapped;
        apb_read(12'h0F4, rd);
        check(rd == 32'h0, "R9 unmapped read below sink0", rd, 32'h0);
        apb_write(12'h118, 32'hFFFF_FFFF);
        apb_read(12'h118, rd);
        check(rd == 32'h0, "R9 unmapped read after write", rd, 32'h0);
        apb_read(12'h114, rd);
        check(rd == 32'hA5A5_0003, "R9 neighbour unchanged", rd, 32'hA5A5_0003);
        apb_read(12'h108, rd);
        check(rd == 32'h0, "R9 sink1 word0 unchanged", rd, 32'h0);
    endtask

    task automatic t_stall;
        @(negedge clk);
        snk_ready = 2'b10;
        send_beat(1'b0, 7'd37, 32'hAAAA_0001, 1'b1, "R7 stalled beat held");
        // drop beat while stalled
        in_valid = 1'b1; in_dest = 1'b0; in_id = 7'd10; in_data = 32'hDEAD_000A;
        #1 check(in_ready == 1'b1, "R8 drop accepted during stall", {31'b0, in_ready}, 32'h1);
        @(negedge clk);
        #1 check(snk_data == 32'hAAAA_0001 && snk_valid == 2'b01, "R8 stalled beat intact",
                 snk_data, 32'hAAAA_0001);
        // passing beat must wait
        in_id = 7'd37; in_data = 32'hAAAA_0002;
        #1 check(in_ready == 1'b0, "R7 passing beat blocked", {31'b0, in_ready}, 32'h0);
        @(negedge clk);
        #1 check(snk_data == 32'hAAAA_0001 && snk_id == 7'd37, "R7 held stable",
                 snk_data, 32'hAAAA_0001);
        snk_ready = 2'b11;
        #1 check(in_ready == 1'b1, "R7 ready once sink drains", {31'b0, in_ready}, 32'h1);
        @(negedge clk);
        in_valid = 1'b0;
        #1 check(snk_data == 32'hAAAA_0002 && snk_valid == 2'b01, "R7 next beat after drain",
                 snk_data, 32'hAAAA_0002);
        @(negedge clk);
    endtask

    task automatic t_burst;
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b1; in_dest = 1'b1; in_id = (k % 2 == 0) ? 7'd96 : 7'd97;
            in_data = 32'h5000_0000 + 32'(k);
            #1 check(in_ready == 1'b1, "R11 burst accepted", {31'b0, in_ready}, 32'h1);
            @(negedge clk);
            #1 check(snk_valid == 2'b10 && snk_data == 32'h5000_0000 + 32'(k),
                     "R11 burst order", snk_data, 32'h5000_0000 + 32'(k));
        end
        in_valid = 1'b0;
        @(negedge clk);
        #1 check(snk_valid == 2'b00, "R11 burst drained", {30'b0, snk_valid}, 32'h0);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check(snk_valid == 2'b00, "R1 no valid in reset", {30'b0, snk_valid}, 32'h0);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_locked_write();
        t_map();
        t_update();
        t_unmapped();
        t_stall();
        t_burst();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule